// File: doc/BRIEF.md
# Interrupt acknowledge hold controller

This block sits beside the sequencer of a small 8-bit CPU. At every instruction boundary it decides whether a maskable interrupt request may be taken. The decoder reports each boundary with a one-cycle end-of-instruction strobe. With that strobe it gives a class code for the instruction that just finished. The request arrives already qualified by the per-source mask flags. Priority arbitration is done upstream and does not reach this block.

Some instructions touch the status word, the enable state, or the interrupt flag, mask or priority registers. These form the hold class. A request that is pending when such an instruction ends is not taken at that boundary. It waits at least until the end of the next instruction. A software break is not in the hold class. It clears the enable flag when it completes instead, and that shuts out maskable requests.

The block owns the interrupt-enable flag. The decoder sets or clears it through two strobes. The block clears it itself on a software break and whenever it issues an acknowledge. The one-cycle acknowledge starts the save-and-vector sequence, which lies outside the block.

Top module: `ackh_ctrl`

## Requirements
- R1: While `rst_n` is low, `irq_ack`, `ie_flag` and `hold_window` are all 0, and the reset takes effect without waiting for a clock edge.
- R2: `irq_ack` is 1 in exactly the cycles where `instr_done`=1, `irq_req`=1, `ie_flag`=1 and `instr_cls` is 2'b00 (ordinary) or 2'b11 (reserved, treated as ordinary). If the same request stays up into the next boundary, no second acknowledge follows, because the enable flag is then 0.
- R3: With `instr_done`=0, `irq_ack` stays 0 whatever the other inputs are.
- R4: At a boundary with `instr_cls`=2'b01 (hold class), `irq_ack` is 0. From the next cycle, `hold_window` is 1 and stays 1 until the next boundary.
- R5: At the first ordinary boundary after a hold-class one, a request that is still present with `ie_flag`=1 is acknowledged. `hold_window` is 0 in the following cycle.
- R6: Several hold-class instructions back to back keep `hold_window` at 1 and block every one of their boundaries. The acknowledge comes at the end of the first ordinary instruction after them.
- R7: If the request drops during the hold window, no acknowledge is issued at the boundary that closes the window.
- R8: At a boundary with `instr_cls`=2'b10 (software break), `irq_ack` is 0 and `ie_flag` is 0 from the next cycle.
- R9: In the cycle after an acknowledge, `ie_flag` is 0.
- R10: With `ie_flag`=0, a pending request is not acknowledged at any boundary.
- R11: `ie_set` makes `ie_flag` 1 in the next cycle. `ie_clr`, a software break boundary or an acknowledge in the same cycle overrides the set, and `ie_flag` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| instr_done | input | 1 | One-cycle strobe marking the end of an instruction |
| instr_cls | input | 2 | Class of the finishing instruction: 00 ordinary, 01 hold, 10 break, 11 ordinary |
| irq_req | input | 1 | Mask-qualified maskable interrupt request |
| ie_set | input | 1 | Set the interrupt-enable flag |
| ie_clr | input | 1 | Clear the interrupt-enable flag |
| irq_ack | output | 1 | One-cycle acknowledge that starts the save-and-vector sequence |
| ie_flag | output | 1 | Current interrupt-enable flag |
| hold_window | output | 1 | 1 while the instruction that follows a hold-class one is executing |

## Verification
The hardest state to reach is a chain of hold-class boundaries with a request present at each one and the enable flag still 1. It is followed either by an ordinary boundary with the request still up, or by one where the request has dropped. Each such scene needs the enable flag re-armed first through `ie_set`, because every acknowledge and every break clears it. The stimulus table therefore puts a set cycle in front of each scene. It then steps through hold, hold, ordinary, and through hold followed by an ordinary boundary without the request. A directed check after that shows that a request held across two consecutive boundaries produces only one acknowledge.

// File: rtl/ackh_pkg.sv
package ackh_pkg;
  localparam int unsigned CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ORD  = 2'b00,
    CLS_HOLD = 2'b01,
    CLS_BRK  = 2'b10,
    CLS_RSV  = 2'b11
  } instr_cls_e;
endpackage

// File: rtl/ackh_gate.sv
module ackh_gate
  import ackh_pkg::*;
(
  input  logic             instr_done,
  input  logic [CLS_W-1:0] instr_cls,
  input  logic             irq_req,
  input  logic             ie_q,
  output logic             ack,
  output logic             hold_hit,
  output logic             brk_hit
);
  instr_cls_e cls;

  always_comb begin
    cls      = instr_cls_e'(instr_cls);
    hold_hit = instr_done && (cls == CLS_HOLD);
    brk_hit  = instr_done && (cls == CLS_BRK);
    // acknowledge only at a boundary that neither holds nor breaks
    ack      = instr_done && irq_req && ie_q && !hold_hit && !brk_hit;
  end
endmodule

// File: rtl/ackh_hold.sv
module ackh_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_done,
  input  logic hold_hit,
  output logic hold_q
);
  logic hold_d;

  always_comb begin
    hold_d = hold_q;
    if (instr_done) hold_d = hold_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end
endmodule

// File: rtl/ackh_ie.sv
module ackh_ie (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic ie_q
);
  logic ie_d;
  logic ie_en;

  always_comb begin
    ie_en = set_req || clr_req;
    ie_d  = ie_q;
    if (ie_en) ie_d = !clr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= 1'b0;
    else if (ie_en) ie_q <= ie_d;
  end
endmodule

// File: rtl/ackh_ctrl.sv
module ackh_ctrl
  import ackh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_done,
  input  logic [CLS_W-1:0] instr_cls,
  input  logic             irq_req,
  input  logic             ie_set,
  input  logic             ie_clr,
  output logic             irq_ack,
  output logic             ie_flag,
  output logic             hold_window
);
  logic ack_w;
  logic hold_hit_w;
  logic brk_hit_w;
  logic ie_w;
  logic clr_any;

  ackh_gate u_gate (
    .instr_done (instr_done),
    .instr_cls  (instr_cls),
    .irq_req    (irq_req),
    .ie_q       (ie_w),
    .ack        (ack_w),
    .hold_hit   (hold_hit_w),
    .brk_hit    (brk_hit_w)
  );

  ackh_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_done (instr_done),
    .hold_hit   (hold_hit_w),
    .hold_q     (hold_window)
  );

  assign clr_any = ie_clr || ack_w || brk_hit_w;

  ackh_ie u_ie (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (ie_set),
    .clr_req (clr_any),
    .ie_q    (ie_w)
  );

  assign irq_ack = ack_w;
  assign ie_flag = ie_w;
endmodule

// File: rtl/ackh_ctrl_chk.sv
module ackh_ctrl_chk
  import ackh_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             instr_done,
  input logic [CLS_W-1:0] instr_cls,
  input logic             irq_req,
  input logic             ie_set,
  input logic             ie_clr,
  input logic             irq_ack,
  input logic             ie_flag,
  input logic             hold_window
);
  // R2
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (instr_done && irq_req));
  // R10
  ack_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> ie_flag);
  // R4
  hold_blocks_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && instr_cls == CLS_HOLD) |-> !irq_ack);
  // R4
  hold_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && instr_cls == CLS_HOLD) |=> hold_window);
  // R5
  window_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && instr_cls != CLS_HOLD) |=> !hold_window);
  // R9
  ack_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !ie_flag);
  // R8
  brk_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && instr_cls == CLS_BRK) |=> !ie_flag);
  // R8
  brk_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && instr_cls == CLS_BRK) |-> !irq_ack);
  // R11
  ie_set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_set && !ie_clr && !irq_ack && !(instr_done && instr_cls == CLS_BRK)) |=> ie_flag);
  // R3
  no_ack_off_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |-> !irq_ack);
endmodule

bind ackh_ctrl ackh_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_done  (instr_done),
  .instr_cls   (instr_cls),
  .irq_req     (irq_req),
  .ie_set      (ie_set),
  .ie_clr      (ie_clr),
  .irq_ack     (irq_ack),
  .ie_flag     (ie_flag),
  .hold_window (hold_window)
);

// File: tb/ackh_ctrl_tb.sv
module ackh_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic       instr_done;
  logic [1:0] instr_cls;
  logic       irq_req;
  logic       ie_set;
  logic       ie_clr;
  logic       irq_ack;
  logic       ie_flag;
  logic       hold_window;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  ackh_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_done  (instr_done),
    .instr_cls   (instr_cls),
    .irq_req     (irq_req),
    .ie_set      (ie_set),
    .ie_clr      (ie_clr),
    .irq_ack     (irq_ack),
    .ie_flag     (ie_flag),
    .hold_window (hold_window)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: set clr done cls req | ack ie_next hold_next | requirement number
  localparam int NV = 19;
  localparam logic [12:0] VEC [NV] = '{
    13'b0_0_1_00_1_0_0_0_1010, // R10 enable still 0
    13'b1_0_0_00_0_0_1_0_1011, // R11 set
    13'b0_0_0_00_1_0_1_0_0011, // R3 no strobe
    13'b0_0_1_00_1_1_0_0_0010, // R2 ack, R9 ie cleared
    13'b1_0_0_00_0_0_1_0_1011, // R11
    13'b0_0_1_01_1_0_1_1_0100, // R4 hold boundary
    13'b0_0_0_00_1_0_1_1_0100, // R4 window persists
    13'b0_0_1_00_1_1_0_0_0101, // R5 ack after window
    13'b1_0_0_00_0_0_1_0_1011, // R11
    13'b0_0_1_01_1_0_1_1_0110, // R6
    13'b0_0_1_01_1_0_1_1_0110, // R6 second hold
    13'b0_0_1_00_1_1_0_0_0110, // R6 ack at first ordinary
    13'b1_0_0_00_0_0_1_0_1011, // R11
    13'b0_0_1_01_1_0_1_1_0111, // R7
    13'b0_0_1_00_0_0_1_0_0111, // R7 withdrawn, no ack
    13'b0_0_1_10_1_0_0_0_1000, // R8 break
    13'b1_1_0_00_0_0_0_0_1011, // R11 clear wins
    13'b1_0_1_00_1_0_1_0_1010, // R10 no ack, then set
    13'b0_0_1_11_1_1_0_0_0010  // R2 reserved class is ordinary
  };

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    instr_done = 1'b0; instr_cls = 2'b00; irq_req = 1'b0;
    ie_set = 1'b0; ie_clr = 1'b0;
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "ack", irq_ack, 1'b0);
    check("R1", "ie", ie_flag, 1'b0);
    check("R1", "hold", hold_window, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[3:0]);
      @(negedge clk);
      ie_set = v[12]; ie_clr = v[11]; instr_done = v[10];
      instr_cls = v[9:8]; irq_req = v[7];
      #2;
      check(tag, $sformatf("ack vec%0d", i), irq_ack, v[6]);
      @(posedge clk);
      #1;
      idle();
      check(tag, $sformatf("ie vec%0d", i), ie_flag, v[5]);
      check(tag, $sformatf("hold vec%0d", i), hold_window, v[4]);
    end

    // R2: request held over two boundaries gives one acknowledge
    @(negedge clk); ie_set = 1'b1;
    @(negedge clk); idle(); instr_done = 1'b1; irq_req = 1'b1;
    #2 check("R2", "first ack", irq_ack, 1'b1);
    @(negedge clk);
    #2 check("R2", "no second ack", irq_ack, 1'b0);
    @(negedge clk); idle();

    // R1: asynchronous reset mid-run with enable and window set
    ie_set = 1'b1;
    @(negedge clk); idle(); instr_done = 1'b1; instr_cls = 2'b01; irq_req = 1'b1;
    @(negedge clk); idle();
    check("R1", "pre hold", hold_window, 1'b1);
    #1 rst_n = 1'b0;
    #1;
    check("R1", "async ie", ie_flag, 1'b0);
    check("R1", "async hold", hold_window, 1'b0);
    check("R1", "async ack", irq_ack, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule